// File: doc/BRIEF.md
# Transmit Packet Aligner with NOP Padding

This block takes a stream of 32-bit doublewords from user logic and builds the 64-bit words sent on a link transmit path. User logic writes each packet as a command followed by its data doublewords. A command is either one doubleword (narrow) or two doublewords (wide). The block places every command at the lower half of a fresh 64-bit word. A narrow command gets an idle NOP in the upper half. Data doublewords are packed in pairs, lower half first. When the data count is odd, a NOP fills the upper half of the last word. This means every packet begins in the lower doubleword.

Along with each 64-bit word the block gives two control flags, one for each half. A flag is high for a command or NOP half and low for a data half. Both sides use valid/ready handshakes. A single output register decouples the two sides, so the block runs at one doubleword per cycle when the link side is ready.

Top module: `tpa_aligner`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: A narrow command goes out alone as {NOP, command}, with out_ctl = 2'b11. The NOP doubleword is all zeros, because the NOP command code is 6'h00.
- R3: A wide command's two input doublewords go out as one word {second, first}, with out_ctl = 2'b11.
- R4: Command bit 4 set means data follows. The data count is the value in command bits [25:22] plus one (1 to 16 doublewords). Data goes out in pairs {later, earlier} with out_ctl = 2'b00.
- R5: For an odd data count, the last data doubleword goes out as {NOP, data} with out_ctl = 2'b10.
- R6: The command of the next packet always occupies the lower half of a new output word, whatever the length of the previous packet.
- R7: While out_valid is high and out_ready is low, out_data and out_ctl hold steady and in_ready is low. No word is dropped or duplicated under backpressure.
- R8: Command bit 5 selects the command width: 1 means two doublewords, 0 means one. The command code field is bits [5:0].
- R9: In out_ctl, bit 0 flags the lower half and bit 1 flags the upper half. A flag is 1 for command or NOP and 0 for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input doubleword valid |
| in_ready | output | 1 | Block can take a doubleword |
| in_data | input | 32 | Input doubleword (command or data) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Link side takes the word |
| out_data | output | 64 | Assembled link word |
| out_ctl | output | 2 | Per-half control flags |

## Verification
The bench covers the following corner cases:
- Odd data counts, including a single data doubleword. A design that skipped the padding would start the next command in the upper half, and every later word would be misaligned.
- Wide commands that carry no data, and the maximum count of sixteen doublewords. Off-by-one mistakes in the count-minus-one decode show up as a lost doubleword or an extra one.
- Long stretches of backpressure. A design that overwrote its output register, or accepted input while stalled, would lose or repeat words, and the word-by-word comparison against the bench model catches this.

// File: rtl/tpa_pkg.sv
`timescale 1ns/1ps
package tpa_pkg;
    localparam int DW       = 32;
    localparam int OWW      = 2 * DW;
    localparam int OP_W     = 6;
    localparam int CNT_W    = 4;
    localparam int CNT_LSB  = 22;
    localparam int WIDE_BIT = 5;
    localparam int DATA_BIT = 4;
    localparam logic [OP_W-1:0] NOP_OP = '0;

    typedef logic [DW-1:0] dword_t;

    typedef enum logic [1:0] {
        ST_CMD    = 2'd0,
        ST_CMD_HI = 2'd1,
        ST_DATA   = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic             wide;
        logic             has_data;
        logic [CNT_W:0]   dwords;
    } cmd_info_t;

    typedef struct packed {
        logic hold;
        logic emit;
        logic solo;
        logic ctl;
    } act_t;

    function automatic dword_t nop_word();
        dword_t w;
        w = '0;
        w[OP_W-1:0] = NOP_OP;
        return w;
    endfunction

    function automatic cmd_info_t decode_cmd(input logic [OP_W-1:0] op,
                                             input logic [CNT_W-1:0] cnt);
        cmd_info_t i;
        i.wide     = op[WIDE_BIT];
        i.has_data = op[DATA_BIT];
        i.dwords   = {1'b0, cnt} + 1'b1;
        return i;
    endfunction
endpackage

// File: rtl/tpa_decode.sv
`timescale 1ns/1ps
module tpa_decode
    import tpa_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [CNT_W-1:0] cnt,
    output cmd_info_t        info
);
    always_comb info = decode_cmd(op, cnt);
endmodule

// File: rtl/tpa_seq.sv
`timescale 1ns/1ps
module tpa_seq
    import tpa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  cmd_info_t info,
    output act_t      act,
    output logic      upper,
    output seq_st_e   st
);
    logic [CNT_W:0] rem;
    logic           pend_data;
    logic [CNT_W:0] pend_cnt;

    // Placement of the incoming doubleword, given the packet position
    always_comb begin
        act = '0;
        case (st)
            ST_CMD: begin
                act.ctl = 1'b1;
                if (info.wide) act.hold = 1'b1;
                else begin
                    act.emit = 1'b1;
                    act.solo = 1'b1;
                end
            end
            ST_CMD_HI: begin
                act.ctl  = 1'b1;
                act.emit = 1'b1;
            end
            ST_DATA: begin
                act.ctl = 1'b0;
                if (upper) act.emit = 1'b1;
                else if (rem == 1) begin
                    act.emit = 1'b1;
                    act.solo = 1'b1;
                end else act.hold = 1'b1;
            end
            default: act = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_CMD;
            rem       <= '0;
            upper     <= 1'b0;
            pend_data <= 1'b0;
            pend_cnt  <= '0;
        end else if (fire) begin
            case (st)
                ST_CMD: begin
                    if (info.wide) begin
                        st        <= ST_CMD_HI;
                        upper     <= 1'b1;
                        pend_data <= info.has_data;
                        pend_cnt  <= info.dwords;
                    end else if (info.has_data) begin
                        st  <= ST_DATA;
                        rem <= info.dwords;
                    end
                end
                ST_CMD_HI: begin
                    upper <= 1'b0;
                    if (pend_data) begin
                        st  <= ST_DATA;
                        rem <= pend_cnt;
                    end else st <= ST_CMD;
                end
                ST_DATA: begin
                    rem   <= rem - 1'b1;
                    upper <= act.hold;
                    if (rem == 1) st <= ST_CMD;
                end
                default: st <= ST_CMD;
            endcase
        end
    end

    // R4
    data_count_live_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (rem != 0));

    // R6
    last_data_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && st == ST_DATA && rem == 1) |=> (st == ST_CMD && !upper));
endmodule

// File: rtl/tpa_pack.sv
`timescale 1ns/1ps
module tpa_pack
    import tpa_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           fire,
    input  act_t           act,
    input  dword_t         in_data,
    input  logic           out_ready,
    output logic           out_valid,
    output logic [OWW-1:0] out_data,
    output logic [1:0]     out_ctl,
    output logic           lo_full,
    output logic           slot_free
);
    dword_t lo;
    logic   lo_ctl;

    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ctl   <= '0;
            lo        <= '0;
            lo_ctl    <= 1'b0;
            lo_full   <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (fire && act.hold) begin
                lo      <= in_data;
                lo_ctl  <= act.ctl;
                lo_full <= 1'b1;
            end
            if (fire && act.emit) begin
                out_valid <= 1'b1;
                if (act.solo) begin
                    out_data <= {nop_word(), in_data};
                    out_ctl  <= {1'b1, act.ctl};
                end else begin
                    out_data <= {in_data, lo};
                    out_ctl  <= {act.ctl, lo_ctl};
                    lo_full  <= 1'b0;
                end
            end
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctl)));

    // R4
    pair_needs_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && act.emit && !act.solo) |-> lo_full);

    // R2
    solo_lower_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && act.emit && act.solo) |-> !lo_full);

    // R9
    ctl_legal_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_ctl != 2'b01));
endmodule

// File: rtl/tpa_aligner.sv
`timescale 1ns/1ps
module tpa_aligner
    import tpa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [63:0] out_data,
    output logic [1:0]  out_ctl
);
    cmd_info_t info;
    act_t      act;
    seq_st_e   st;
    logic      upper;
    logic      lo_full;
    logic      slot_free;
    logic      fire;

    assign in_ready = slot_free;
    assign fire     = in_valid && slot_free;

    tpa_decode u_dec (
        .op   (in_data[OP_W-1:0]),
        .cnt  (in_data[CNT_LSB +: CNT_W]),
        .info (info)
    );

    tpa_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .info  (info),
        .act   (act),
        .upper (upper),
        .st    (st)
    );

    tpa_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .act       (act),
        .in_data   (in_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ctl   (out_ctl),
        .lo_full   (lo_full),
        .slot_free (slot_free)
    );

    // R6
    half_track_chk: assert property (@(posedge clk) disable iff (rst)
        upper == lo_full);

    // R6
    cmd_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMD) |-> !lo_full);
endmodule

// File: tb/tpa_aligner_tb.sv
`timescale 1ns/1ps
module tpa_aligner_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic [1:0]  out_ctl;

    int checks = 0;
    int errors = 0;

    logic [31:0] in_q[$];
    logic [63:0] exp_d[$];
    logic [1:0]  exp_c[$];
    string       exp_t[$];
    bit          prev_odd = 0;

    localparam int LIMIT = 150000;
    int total_cycles = 0;

    always #10 clk = ~clk;

    tpa_aligner u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_ctl(out_ctl)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nz();
        logic [31:0] v;
        v = $urandom;
        if (v == 0) v = 32'h1;
        return v;
    endfunction

    // Bench model: push one packet and the words it must produce
    task automatic add_pkt(input bit wide, input int n);
        logic [31:0] cmd, w2, d0, d1;
        logic [5:0]  op;
        string       tag;
        cmd = $urandom;
        op  = {wide, (n != 0), 4'($urandom)};
        cmd[5:0] = op;
        if (n != 0) cmd[25:22] = 4'(n - 1);
        tag = wide ? "R3 R8 R9" : "R2 R8 R9";
        if (prev_odd) tag = {tag, " R6"};
        in_q.push_back(cmd);
        if (wide) begin
            w2 = nz();
            in_q.push_back(w2);
            exp_d.push_back({w2, cmd});
        end else exp_d.push_back({32'h0, cmd});
        exp_c.push_back(2'b11);
        exp_t.push_back(tag);
        for (int k = 0; k + 1 < n; k += 2) begin
            d0 = nz(); d1 = nz();
            in_q.push_back(d0); in_q.push_back(d1);
            exp_d.push_back({d1, d0}); exp_c.push_back(2'b00);
            exp_t.push_back("R4 R9");
        end
        if (n % 2 == 1) begin
            d0 = nz();
            in_q.push_back(d0);
            exp_d.push_back({32'h0, d0}); exp_c.push_back(2'b10);
            exp_t.push_back("R5 R9");
        end
        prev_odd = (n % 2 == 1);
    endtask

    task automatic run(input int vmod, input int rmod);
        int idx = 0;
        bit prev_stall = 0;
        logic [63:0] pd = '0;
        logic [1:0]  pc = '0;
        while ((idx < in_q.size() || exp_d.size() > 0) && total_cycles < LIMIT) begin
            @(negedge clk);
            total_cycles++;
            if (prev_stall)
                chk(out_data == pd && out_ctl == pc, "R7 held word",
                    {out_ctl, out_data}, {pc, pd});
            in_valid  = (idx < in_q.size()) && (($urandom % vmod) != 0);
            in_data   = (idx < in_q.size()) ? in_q[idx] : 32'h0;
            out_ready = (($urandom % rmod) != 0);
            #1;
            if (out_valid && !out_ready)
                chk(in_ready == 1'b0, "R7 in_ready during stall",
                    {65'b0, in_ready}, 66'b0);
            if (out_valid && out_ready) begin
                if (exp_d.size() == 0)
                    chk(1'b0, "R7 extra word", {out_ctl, out_data}, 66'b0);
                else begin
                    chk(out_data == exp_d[0] && out_ctl == exp_c[0], exp_t[0],
                        {out_ctl, out_data}, {exp_c[0], exp_d[0]});
                    void'(exp_d.pop_front());
                    void'(exp_c.pop_front());
                    void'(exp_t.pop_front());
                end
            end
            if (in_valid && in_ready) idx++;
            prev_stall = out_valid && !out_ready;
            pd = out_data;
            pc = out_ctl;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        in_q.delete();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", {65'b0, out_valid}, 66'b0);
        chk(in_ready == 1'b1, "R1 in_ready", {65'b0, in_ready}, 66'b1);

        // Directed corner cases under heavy backpressure
        add_pkt(0, 0);
        add_pkt(1, 0);
        add_pkt(0, 1);
        add_pkt(0, 2);
        add_pkt(1, 1);
        add_pkt(1, 2);
        add_pkt(0, 16);
        add_pkt(1, 15);
        add_pkt(0, 3);
        run(2, 4);
        run(1, 1);

        // Random packets
        for (int p = 0; p < 300; p++)
            add_pkt(1'($urandom), ($urandom % 2 == 0) ? 0 : int'($urandom % 16) + 1);
        run(3, 3);

        if (total_cycles >= LIMIT) begin
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected<%0d", total_cycles, LIMIT);
        end
        chk(exp_d.size() == 0, "R7 all words delivered",
            66'(exp_d.size()), 66'b0);
        chk(out_valid == 1'b0, "R6 idle after drain", {65'b0, out_valid}, 66'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule